// File: doc/BRIEF.md
# Two-Port GPIO Register Bank

This block holds the configuration and data state of two general-purpose I/O ports and drives their pins. A host reaches it through a byte-wide register interface: a single-cycle write strobe with an 8-bit offset and data, and a read strobe whose answer comes back, marked valid, one cycle later. Each port has its own direction, data and inversion registers. One bit per port in a shared enable register switches the port on. One bit per port in a drive-mode register selects push-pull or open-drain output.

A 2-bit function-select field decides whether the pins belong to the GPIO function at all. Unless that field holds the GPIO code and the port is enabled, no pin of the port drives. Pin inputs cross a two-flop synchronizer before the data register reports them. The inversion register is plain storage: the host applies the polarity itself, and the pins do not see it. The second port is a narrow variant with `PINS_B` pins, 5 by default. Its unused upper register bits read as 0.

Top module: `gpio_bank`

## Requirements
- R1: After reset every direction bit is 1 (input), the data, inversion, enable, drive-mode and function-select registers are 0, and no pin output enable is asserted.
- R2: The register offsets are as follows. Port A uses 0xE0 for direction, 0xE1 for data and 0xE2 for inversion. Port B uses 0xE4, 0xE5 and 0xE6 in the same roles. The enable register is 0x30, with bit 0 for port A and bit 1 for port B. The function select is bits [1:0] of 0x28. The drive mode is 0x29, with bit 0 for port A and bit 1 for port B. Unused bits of 0x28, 0x29 and 0x30 read as 0. A read strobe in cycle n gives `rd_valid` high and the register value on `rd_data` in cycle n+1.
- R3: A direction bit of 1 makes the pin an input, and an input pin's output enable is never asserted. Reading the data register returns the synchronized pin level for input bits and the stored value for output bits.
- R4: A pin input change takes two clock edges to reach the data register's read value. A read captured at the first or second edge after the change returns the old level; a read at the third edge returns the new one.
- R5: With the port active and its drive-mode bit at 1 (push-pull), each output pin has its output enable asserted and drives its data bit.
- R6: With the drive-mode bit at 0 (open-drain), each output pin drives 0. Its output enable is asserted for data 0 and released for data 1.
- R7: A port is active only when its enable bit is 1 and the function select holds 2. The values 0, 1 and 3 of the function select, or an enable bit of 0, deassert every output enable of the port.
- R8: The inversion registers read back what was written and have no effect on pin outputs or output enables.
- R9: On port B, bits at and above `PINS_B` of its direction, data and inversion registers read 0 and ignore writes.
- R10: Reads of an unmapped offset return 0, and writes to one change no register and no pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| addr | input | 8 | Register offset |
| wdata | input | 8 | Write data |
| rd_valid | output | 1 | Read answer valid, one cycle after `rd_en` |
| rd_data | output | 8 | Read answer |
| pin_a_in | input | PINS_A | Port A pin levels (asynchronous) |
| pin_a_out | output | PINS_A | Port A pin output values |
| pin_a_oe | output | PINS_A | Port A pin output enables |
| pin_b_in | input | PINS_B | Port B pin levels (asynchronous) |
| pin_b_out | output | PINS_B | Port B pin output values |
| pin_b_oe | output | PINS_B | Port B pin output enables |

## Verification
On every cycle, the assertions check the following. An input pin never gets an output enable. An open-drain pin never enables a bit whose data is 1. An inactive port drives nothing. The synchronizer output is the pin level from exactly two edges before. A read answer is valid exactly one cycle after its strobe. Other behaviours show only in the bench scenarios:
- the register offsets and the masking of unused bits on readback;
- the exact read cycle at which a changed pin level first appears;
- each of the three non-GPIO function-select codes;
- the inertness of the inversion registers and of unmapped offsets.

// File: rtl/gpio_bank_pkg.sv
// Shared constants of the GPIO register bank: register offsets and the
// function-select code that hands the pins to the GPIO function.
package gpio_bank_pkg;
    localparam int NPORTS = 2;
    localparam logic [7:0] OFS_PORT_A = 8'hE0;
    localparam logic [7:0] OFS_PORT_B = 8'hE4;
    localparam logic [7:0] OFS_ENABLE = 8'h30;
    localparam logic [7:0] OFS_FUNSEL = 8'h28;
    localparam logic [7:0] OFS_DRIVE  = 8'h29;

    typedef enum logic [1:0] {
        FN_OTHER0 = 2'd0,
        FN_OTHER1 = 2'd1,
        FN_GPIO   = 2'd2,
        FN_OTHER3 = 2'd3
    } funsel_e;
endpackage

// File: rtl/gpio_bank_sync.sv
// Two-flop synchronizer for asynchronous pin levels.
// Assumes reset is held for at least two clock edges; the data flops are
// not reset, so after that they carry true pin history.
module gpio_bank_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Two-stage capture of the asynchronous input.
    always_ff @(posedge clk) begin
        meta_q <= din;
        sync_q <= meta_q;
    end

    assign dout = sync_q;

    // R4
    sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_q == $past(din, 2));
endmodule

// File: rtl/gpio_bank_port.sv
// One GPIO port: direction, data and inversion registers at BASE, BASE+1
// and BASE+2, an input synchronizer and per-pin drive logic.
// Assumes PINS is between 1 and 8; writes outside its offsets are ignored.
module gpio_bank_port
    import gpio_bank_pkg::*;
#(
    parameter int          PINS = 8,
    parameter logic [7:0]  BASE = OFS_PORT_A
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [7:0]      addr,
    input  logic [PINS-1:0] wdata,
    input  logic            active,
    input  logic            push_pull,
    input  logic [PINS-1:0] pin_in,
    output logic [PINS-1:0] pin_out,
    output logic [PINS-1:0] pin_oe,
    output logic            rd_hit,
    output logic [PINS-1:0] rd_val
);
    localparam logic [7:0] ADR_DIR = BASE;
    localparam logic [7:0] ADR_DAT = BASE + 8'd1;
    localparam logic [7:0] ADR_INV = BASE + 8'd2;

    logic [PINS-1:0] dir_q;
    logic [PINS-1:0] data_q;
    logic [PINS-1:0] inv_q;
    logic [PINS-1:0] level_sync;
    logic [PINS-1:0] level_rd;

    gpio_bank_sync #(.W(PINS)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin_in),
        .dout (level_sync)
    );

    // Register writes; direction resets to all inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= '1;
            data_q <= '0;
            inv_q  <= '0;
        end else if (wr_en) begin
            if (addr == ADR_DIR) dir_q  <= wdata;
            if (addr == ADR_DAT) data_q <= wdata;
            if (addr == ADR_INV) inv_q  <= wdata;
        end
    end

    // Data readback: pin level for inputs, stored value for outputs.
    assign level_rd = (dir_q & level_sync) | (~dir_q & data_q);

    // Read selection among the three port registers.
    always_comb begin
        rd_hit = 1'b1;
        rd_val = '0;
        if (addr == ADR_DIR)      rd_val = dir_q;
        else if (addr == ADR_DAT) rd_val = level_rd;
        else if (addr == ADR_INV) rd_val = inv_q;
        else                      rd_hit = 1'b0;
    end

    // Per-pin drive: push-pull drives the data bit, open-drain only pulls low.
    for (genvar i = 0; i < PINS; i++) begin : g_pin
        assign pin_oe[i]  = active & ~dir_q[i] & (push_pull | ~data_q[i]);
        assign pin_out[i] = push_pull & data_q[i];
    end

    // R3
    input_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & dir_q) == '0);

    // R6
    od_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !push_pull |-> ((pin_oe & data_q) == '0 && pin_out == '0));
endmodule

// File: rtl/gpio_bank.sv
// GPIO register bank top: global enable, drive-mode and function-select
// registers, two port instances and a registered read path.
// Assumes single-cycle strobes; a read answers one cycle after its strobe.
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int PINS_A = 8,
    parameter int PINS_B = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [7:0]        addr,
    input  logic [7:0]        wdata,
    output logic              rd_valid,
    output logic [7:0]        rd_data,
    input  logic [PINS_A-1:0] pin_a_in,
    output logic [PINS_A-1:0] pin_a_out,
    output logic [PINS_A-1:0] pin_a_oe,
    input  logic [PINS_B-1:0] pin_b_in,
    output logic [PINS_B-1:0] pin_b_out,
    output logic [PINS_B-1:0] pin_b_oe
);
    localparam int PAD = 8 - NPORTS;

    logic [NPORTS-1:0] en_q;
    logic [NPORTS-1:0] drv_q;
    funsel_e           fsel_q;
    logic [NPORTS-1:0] act;
    logic              a_hit, b_hit;
    logic [PINS_A-1:0] a_val;
    logic [PINS_B-1:0] b_val;
    logic [7:0]        rd_next;

    // Global register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            drv_q  <= '0;
            fsel_q <= FN_OTHER0;
        end else if (wr_en) begin
            if (addr == OFS_ENABLE) en_q   <= wdata[NPORTS-1:0];
            if (addr == OFS_DRIVE)  drv_q  <= wdata[NPORTS-1:0];
            if (addr == OFS_FUNSEL) fsel_q <= funsel_e'(wdata[1:0]);
        end
    end

    // A port is active when enabled and the pins belong to GPIO.
    assign act = en_q & {NPORTS{fsel_q == FN_GPIO}};

    gpio_bank_port #(.PINS(PINS_A), .BASE(OFS_PORT_A)) u_port_a (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata[PINS_A-1:0]), .active(act[0]), .push_pull(drv_q[0]),
        .pin_in(pin_a_in), .pin_out(pin_a_out), .pin_oe(pin_a_oe),
        .rd_hit(a_hit), .rd_val(a_val)
    );

    gpio_bank_port #(.PINS(PINS_B), .BASE(OFS_PORT_B)) u_port_b (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata[PINS_B-1:0]), .active(act[1]), .push_pull(drv_q[1]),
        .pin_in(pin_b_in), .pin_out(pin_b_out), .pin_oe(pin_b_oe),
        .rd_hit(b_hit), .rd_val(b_val)
    );

    // Read value selection; unmapped offsets give 0.
    always_comb begin
        if (addr == OFS_ENABLE)      rd_next = {{PAD{1'b0}}, en_q};
        else if (addr == OFS_DRIVE)  rd_next = {{PAD{1'b0}}, drv_q};
        else if (addr == OFS_FUNSEL) rd_next = {6'd0, fsel_q};
        else if (a_hit)              rd_next = 8'(a_val);
        else if (b_hit)              rd_next = 8'(b_val);
        else                         rd_next = 8'd0;
    end

    // Registered read answer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= 8'd0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_data <= rd_next;
        end
    end

    // R2
    rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid == ($past(rd_en) && $past(rst_n)));

    // R7
    port_a_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q[0] || fsel_q != FN_GPIO) |-> pin_a_oe == '0);

    // R7
    port_b_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q[1] || fsel_q != FN_GPIO) |-> pin_b_oe == '0);
endmodule

// File: tb/gpio_bank_bench.sv
// Scoreboard bench: the read task queues expected values, a monitor pops
// and compares them when rd_valid comes back; pin checks run directly.
module gpio_bank_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] addr = 8'd0, wdata = 8'd0;
    logic       rd_valid;
    logic [7:0] rd_data;
    logic [7:0] pin_a_in = 8'd0, pin_a_out, pin_a_oe;
    logic [4:0] pin_b_in = 5'd0, pin_b_out, pin_b_oe;

    int    errors = 0;
    int    checks = 0;
    bit    done = 1'b0;
    byte   exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    gpio_bank u_gpio_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rd_valid(rd_valid), .rd_data(rd_data),
        .pin_a_in(pin_a_in), .pin_a_out(pin_a_out), .pin_a_oe(pin_a_oe),
        .pin_b_in(pin_b_in), .pin_b_out(pin_b_out), .pin_b_oe(pin_b_oe)
    );

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
        rd_en = 1'b1; addr = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic chk_a(input logic [7:0] eo, input logic [7:0] ee, input string tag);
        checks++;
        if (pin_a_out !== eo || pin_a_oe !== ee) begin
            errors++;
            $display("FAIL %s port A: actual out=%h oe=%h expected out=%h oe=%h",
                     tag, pin_a_out, pin_a_oe, eo, ee);
        end
    endtask

    task automatic chk_b(input logic [4:0] eo, input logic [4:0] ee, input string tag);
        checks++;
        if (pin_b_out !== eo || pin_b_oe !== ee) begin
            errors++;
            $display("FAIL %s port B: actual out=%h oe=%h expected out=%h oe=%h",
                     tag, pin_b_out, pin_b_oe, eo, ee);
        end
    endtask

    // Monitor: compare each read answer with the head of the queue.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R2 unexpected read: actual=%h expected=none", rd_data);
            end else begin
                byte   e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rd_data !== e) begin
                    errors++;
                    $display("FAIL %s read: actual=%h expected=%h", t, rd_data, e);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk_a(8'h00, 8'h00, "R1");
        chk_b(5'h00, 5'h00, "R1");
        rd(8'hE0, 8'hFF, "R1");
        rd(8'hE4, 8'h1F, "R1 R9");
        rd(8'h30, 8'h00, "R1");
        rd(8'hE1, 8'h00, "R1");
        // R2 R8 R9 register map and masking
        wr(8'hE2, 8'hA5);
        rd(8'hE2, 8'hA5, "R2 R8");
        wr(8'hE6, 8'hFF);
        rd(8'hE6, 8'h1F, "R9");
        wr(8'h29, 8'hFF);
        rd(8'h29, 8'h03, "R2");
        wr(8'h28, 8'hFF);
        rd(8'h28, 8'h03, "R2");
        wr(8'h28, 8'h02);
        // R3 input readback
        pin_a_in = 8'h3C;
        repeat (3) @(negedge clk);
        rd(8'hE1, 8'h3C, "R3");
        wr(8'hE0, 8'h0F);
        wr(8'hE1, 8'hA0);
        rd(8'hE1, 8'hAC, "R3");
        // R4 synchronizer latency: old, old, new
        pin_a_in = 8'h03;
        rd(8'hE1, 8'hAC, "R4 first edge");
        rd(8'hE1, 8'hAC, "R4 second edge");
        rd(8'hE1, 8'hA3, "R4 third edge");
        // R5 push-pull
        wr(8'h30, 8'h01);
        chk_a(8'hA0, 8'hF0, "R5");
        // R6 open-drain
        wr(8'h29, 8'h02);
        chk_a(8'h00, 8'h50, "R6");
        // R8 inversion has no pin effect
        wr(8'hE2, 8'h00);
        chk_a(8'h00, 8'h50, "R8");
        // R7 function-select codes and enable
        wr(8'h28, 8'h00);
        chk_a(8'h00, 8'h00, "R7 sel0");
        wr(8'h28, 8'h01);
        chk_a(8'h00, 8'h00, "R7 sel1");
        wr(8'h28, 8'h03);
        chk_a(8'h00, 8'h00, "R7 sel3");
        wr(8'h28, 8'h02);
        chk_a(8'h00, 8'h50, "R7 sel2");
        wr(8'h30, 8'h00);
        chk_a(8'h00, 8'h00, "R7 disabled");
        // R9 narrow port drive
        wr(8'h30, 8'h03);
        wr(8'hE4, 8'h00);
        wr(8'hE5, 8'hFF);
        chk_b(5'h1F, 5'h1F, "R9");
        rd(8'hE5, 8'h1F, "R9");
        // R10 unmapped offsets
        wr(8'h55, 8'hFF);
        wr(8'hE3, 8'hFF);
        rd(8'h55, 8'h00, "R10");
        rd(8'hE3, 8'h00, "R10");
        rd(8'hE1, 8'hA3, "R10");
        chk_a(8'h00, 8'h50, "R10");
        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            errors++; checks++;
            $display("FAIL R2 missing answers: actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule